// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a single-clock synchronous SRAM with a small internal array. Every control, address and data input is captured on the rising clock edge. Write data trails its command by the same two cycles that read data needs to reach the output register. Because of that alignment, a read may follow a write, or a write may follow a read, on the very next cycle with no idle slot on the shared data bus.

Commands are started on a load cycle. On that cycle the three chip selects and the read/write select decide whether a read burst, a write burst or a deselect begins. On advance cycles the same operation continues, and a two-bit burst counter supplies the next address in linear or interleaved order. A completed write waits in a pending register for one extra enabled cycle before it is merged into the array. Any read that reaches the output stage meanwhile sees the new bytes through a forwarding path. A clock-enable input (active low here) freezes the whole block.

The command tracker is a three-state machine. ST_DESEL is idle. ST_RD_BURST is a read burst in progress. ST_WR_BURST is a write burst in progress. On an enabled load cycle the machine takes one of three transitions. T_LOAD_RD goes to ST_RD_BURST when all selects are asserted and the cycle is a read. T_LOAD_WR goes to ST_WR_BURST when all selects are asserted and the cycle is a write. T_LOAD_DESEL goes to ST_DESEL when any select is inactive. On an enabled advance cycle T_ADVANCE keeps the current state, and a stalled cycle also keeps it.

Top module: `zt_sram`

## Requirements
- R1: While rst_n is low and after it is released, rdata_oe is 0 and rdata is all zero, and the tracker starts in ST_DESEL with no pending write.
- R2: A read registered on enabled edge k places the word in the output register at enabled edge k+2, and it is visible on rdata once oe_n is low.
- R3: For a write registered on enabled edge k, wdata and lane_we_n are sampled on enabled edge k+2, and any later read of that address returns the written bytes.
- R4: lane_we_n[i] low writes bits [8*i+7:8*i] of the word. A lane whose enable is high keeps its old contents.
- R5: While clk_en_n is high every input is ignored, and the output register, the pending write, the pipeline, the array and the tracker all hold their values.
- R6: A load cycle starts a read or write only when sel0_n is low, sel1 is high and sel2_n is low. Otherwise the cycle is a deselect: nothing is written and nothing is driven, whatever wr_n says.
- R7: load_n low takes addr as the new burst base and resets the burst count to 0. load_n high continues the previous operation at the next burst address, and the selects and wr_n are ignored on such a cycle. A burst that began as a deselect continues as a deselect.
- R8: The burst address keeps base bits [7:2]. Its bits [1:0] are base[1:0] XOR count when interleave is 1, and (base[1:0] + count) mod 4 when interleave is 0. The count starts at 0 on the load cycle.
- R9: Read and write commands may alternate on every consecutive enabled cycle, and each one completes correctly with no idle cycle between them.
- R10: A read that reaches the output stage while a write to the same address is still pending returns the pending bytes in the enabled lanes and the array bytes in the others.
- R11: rdata_oe is 1 exactly when oe_n is low and the output stage holds a read. While rdata_oe is 0, rdata is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the block |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Low selects write, high selects read, on load cycles |
| load_n | input | 1 | Low loads a new address; high advances the burst |
| interleave | input | 1 | 1 selects interleaved burst order, 0 selects linear order |
| addr | input | ADDR_W | Word address |
| lane_we_n | input | LANES | Per-lane write enable, active low, sampled with write data |
| oe_n | input | 1 | Output enable, active low |
| wdata | input | DATA_W | Write data bus |
| rdata | output | DATA_W | Read data bus, zero when not driven |
| rdata_oe | output | 1 | High when the block drives the data bus |

## Verification
The checker assumes that rst_n is low for at least one edge before the first command, and that interleave is held steady for the length of a burst. The stimulus only toggles interleave on load cycles, so that assumption holds. Reads are only issued to addresses that were written earlier, because the array has no reset and an unwritten word would give an undefined compare. The stimulus therefore fills the low 32 words first and then confines both the random and the directed addresses to that range. Burst addresses change only bits [1:0], so they stay inside the same range.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

    // Tracker states: idle, read burst in progress, write burst in progress
    typedef enum logic [1:0] {
        ST_DESEL    = 2'd0,
        ST_RD_BURST = 2'd1,
        ST_WR_BURST = 2'd2
    } burst_st_e;

    // Operation carried down the pipeline
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
    import zt_sram_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic load,
    input  logic selected,
    input  logic wr,
    output op_e  cmd_op
);

    burst_st_e st_q;
    burst_st_e st_d;

    // Next state: T_LOAD_RD, T_LOAD_WR, T_LOAD_DESEL on load; T_ADVANCE holds
    always_comb begin
        st_d = st_q;
        if (load) begin
            if (!selected)
                st_d = ST_DESEL;
            else if (wr)
                st_d = ST_WR_BURST;
            else
                st_d = ST_RD_BURST;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= ST_DESEL;
        else if (step)
            st_q <= st_d;
    end

    // Outputs
    always_comb begin
        unique case (st_q)
            ST_DESEL:    cmd_op = OP_IDLE;
            ST_RD_BURST: cmd_op = OP_READ;
            ST_WR_BURST: cmd_op = OP_WRITE;
            default:     cmd_op = OP_IDLE;
        endcase
    end

endmodule

// File: rtl/zt_sram_burst.sv
module zt_sram_burst #(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              load,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] cur_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  ofs;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (step) begin
            if (load) begin
                base_q <= addr_in;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= cnt_q + 1'b1;
            end
        end
    end

    // Interleaved order flips offset bits; linear order adds with wrap
    assign ofs      = interleave ? (base_q[CNT_W-1:0] ^ cnt_q)
                                 : (base_q[CNT_W-1:0] + cnt_q);
    assign cur_addr = {base_q[ADDR_W-1:CNT_W], ofs};

endmodule

// File: rtl/zt_sram_store.sv
module zt_sram_store
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     step,
    input  op_e                      s1_op,
    input  logic [ADDR_W-1:0]        s1_addr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [LANES-1:0]         lane_we,
    output logic                     out_rd,
    output logic [LANES*LANE_W-1:0]  out_word,
    output logic                     pend_v
);

    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    op_e               s2_op;
    logic [ADDR_W-1:0] s2_addr;
    logic [ADDR_W-1:0] pend_a;
    logic [DATA_W-1:0] pend_d;
    logic [LANES-1:0]  pend_m;

    logic [DATA_W-1:0] rd_raw;
    logic [DATA_W-1:0] rd_merge;
    logic [DATA_W-1:0] cm_raw;
    logic [DATA_W-1:0] cm_merge;
    logic              fwd_hit;

    assign rd_raw  = mem[s2_addr];
    assign cm_raw  = mem[pend_a];
    assign fwd_hit = pend_v && (pend_a == s2_addr);

    // Per-lane merge for forwarding and for the array commit
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign rd_merge[i*LANE_W +: LANE_W] = (fwd_hit && pend_m[i])
                                             ? pend_d[i*LANE_W +: LANE_W]
                                             : rd_raw[i*LANE_W +: LANE_W];
        assign cm_merge[i*LANE_W +: LANE_W] = pend_m[i]
                                             ? pend_d[i*LANE_W +: LANE_W]
                                             : cm_raw[i*LANE_W +: LANE_W];
    end

    // Array commit of the pending write, one enabled cycle late
    always_ff @(posedge clk) begin
        if (step && pend_v)
            mem[pend_a] <= cm_merge;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_op    <= OP_IDLE;
            s2_addr  <= '0;
            out_rd   <= 1'b0;
            out_word <= '0;
            pend_v   <= 1'b0;
            pend_a   <= '0;
            pend_d   <= '0;
            pend_m   <= '0;
        end else if (step) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            out_rd  <= (s2_op == OP_READ);
            if (s2_op == OP_READ)
                out_word <= rd_merge;
            pend_v  <= (s2_op == OP_WRITE);
            if (s2_op == OP_WRITE) begin
                pend_a <= s2_addr;
                pend_d <= wdata;
                pend_m <= lane_we;
            end
        end
    end

endmodule

// File: rtl/zt_sram.sv
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en_n,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              wr_n,
    input  logic              load_n,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    logic              step;
    logic              load;
    logic              selected;
    op_e               cmd_op;
    logic [ADDR_W-1:0] cur_addr;
    logic              out_is_rd;
    logic [DATA_W-1:0] rdata_q;
    logic              pend_v;

    assign step     = !clk_en_n;
    assign load     = !load_n;
    assign selected = !sel0_n && sel1 && !sel2_n;

    zt_sram_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .load     (load),
        .selected (selected),
        .wr       (!wr_n),
        .cmd_op   (cmd_op)
    );

    zt_sram_burst #(.ADDR_W(ADDR_W), .CNT_W(2)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .load       (load),
        .interleave (interleave),
        .addr_in    (addr),
        .cur_addr   (cur_addr)
    );

    zt_sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (step),
        .s1_op    (cmd_op),
        .s1_addr  (cur_addr),
        .wdata    (wdata),
        .lane_we  (~lane_we_n),
        .out_rd   (out_is_rd),
        .out_word (rdata_q),
        .pend_v   (pend_v)
    );

    assign rdata_oe = out_is_rd && !oe_n;
    assign rdata    = rdata_oe ? rdata_q : '0;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en_n,
    input logic              sel0_n,
    input logic              sel1,
    input logic              sel2_n,
    input logic              wr_n,
    input logic              load_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] rdata,
    input logic              rdata_oe,
    input logic              out_is_rd,
    input logic [DATA_W-1:0] rdata_q,
    input logic              pend_v
);

    // Port-level command tracking: 0 idle, 1 read, 2 write
    logic [1:0] c1, c2, c3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c1 <= 2'd0;
            c2 <= 2'd0;
            c3 <= 2'd0;
        end else if (!clk_en_n) begin
            if (!load_n)
                c1 <= (!sel0_n && sel1 && !sel2_n) ? (wr_n ? 2'd1 : 2'd2) : 2'd0;
            c2 <= c1;
            c3 <= c2;
        end
    end

    // R2: output stage holds a read exactly two enabled edges after the command
    p_read_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_is_rd == (c3 == 2'd1));

    // R3: write data is taken exactly two enabled edges after the command
    p_write_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pend_v == (c3 == 2'd2));

    // R5: a stalled cycle leaves the output and pending state untouched
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en_n |=> ($stable(rdata_q) && $stable(out_is_rd) && $stable(pend_v)));

    // R11: bus driven only for a read at the output stage with oe_n low
    p_drive_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe == (!oe_n && c3 == 2'd1));

    // R11: undriven bus reads as zero
    p_quiet_bus_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !rdata_oe |-> (rdata == '0));

endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_en_n  (clk_en_n),
    .sel0_n    (sel0_n),
    .sel1      (sel1),
    .sel2_n    (sel2_n),
    .wr_n      (wr_n),
    .load_n    (load_n),
    .oe_n      (oe_n),
    .rdata     (rdata),
    .rdata_oe  (rdata_oe),
    .out_is_rd (out_is_rd),
    .rdata_q   (rdata_q),
    .pend_v    (pend_v)
);

// File: tb/zt_sram_tb.sv
module zt_sram_tb;

    localparam int AW = 8;
    localparam int NB = 4;
    localparam int LW = 8;
    localparam int DW = NB * LW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en_n = 1'b0;
    logic          sel0_n = 1'b1;
    logic          sel1 = 1'b0;
    logic          sel2_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          load_n = 1'b0;
    logic          interleave = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NB-1:0] lane_we_n = '1;
    logic          oe_n = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    zt_sram #(.ADDR_W(AW), .LANES(NB), .LANE_W(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .wr_n(wr_n), .load_n(load_n), .interleave(interleave),
        .addr(addr), .lane_we_n(lane_we_n), .oe_n(oe_n),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    always #10 clk = ~clk;

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    bit    done    = 0;
    string tag     = "R1";

    // Bench model
    logic [DW-1:0] mdl [256];
    int            m_st = 0;
    logic [AW-1:0] m_base = '0;
    int            m_cnt = 0;
    int            p2_op = 0;
    logic [AW-1:0] p2_addr = '0;
    bit            exp_v = 0;
    logic [DW-1:0] exp_d = '0;

    // Write-data delay line for directed commands
    logic [DW-1:0] dq_d [2];
    logic [NB-1:0] dq_b [2];
    bit            g_oen = 0;
    bit            g_ilv = 0;
    int            g_selbad = 1;

    function automatic logic [AW-1:0] burst_addr(input logic [AW-1:0] b, input int c, input bit ilv);
        logic [1:0] lo;
        logic [1:0] cc;
        cc = c[1:0];
        lo = ilv ? (b[1:0] ^ cc) : (b[1:0] + cc);
        return {b[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                            input logic [NB-1:0] ben);
        logic [DW-1:0] r;
        r = old;
        for (int i = 0; i < NB; i++)
            if (!ben[i]) r[i*LW +: LW] = nw[i*LW +: LW];
        return r;
    endfunction

    task automatic check(input bit cond, input logic [DW-1:0] act, input logic [DW-1:0] exp_val);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (oe act %0b exp %0b)",
                     tag, act, exp_val, rdata_oe, exp_v && !g_oen);
        end
    endtask

    task automatic cycle(input bit ce, input bit s0n, input bit s1v, input bit s2n,
                         input bit wrn, input bit ldn, input bit ilv,
                         input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input logic [NB-1:0] ben, input bit oen);
        bit            eoe;
        logic [DW-1:0] edat;
        clk_en_n = !ce; sel0_n = s0n; sel1 = s1v; sel2_n = s2n; wr_n = wrn;
        load_n = ldn; interleave = ilv; addr = a; wdata = wd; lane_we_n = ben; oe_n = oen;
        if (ce) begin
            if (p2_op == 1) begin exp_v = 1; exp_d = mdl[p2_addr]; end
            else exp_v = 0;
            if (p2_op == 2) mdl[p2_addr] = merge(mdl[p2_addr], wd, ben);
            p2_op   = m_st;
            p2_addr = burst_addr(m_base, m_cnt, ilv);
            if (!ldn) begin
                m_st   = (!s0n && s1v && !s2n) ? (wrn ? 1 : 2) : 0;
                m_base = a;
                m_cnt  = 0;
            end else begin
                m_cnt  = m_cnt + 1;
            end
        end
        @(posedge clk);
        @(negedge clk);
        eoe  = exp_v && !oen;
        edat = eoe ? exp_d : '0;
        check((rdata_oe === eoe) && (rdata === edat), rdata, edat);
    endtask

    // kind: 0 deselect load, 1 read load, 2 write load, 3 advance
    task automatic op(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [NB-1:0] ben);
        logic [DW-1:0] cwd;
        logic [NB-1:0] cbe;
        int bad;
        bit s0n, s1v, s2n, wrn;
        cwd = dq_d[1]; cbe = dq_b[1];
        dq_d[1] = dq_d[0]; dq_b[1] = dq_b[0];
        dq_d[0] = d;       dq_b[0] = ben;
        bad = (kind == 0) ? ((g_selbad == 0) ? 1 : g_selbad) : 0;
        s0n = (bad == 1); s1v = (bad != 2); s2n = (bad == 3);
        if (kind == 3) begin
            s0n = 1'($urandom); s1v = 1'($urandom); s2n = 1'($urandom);
        end
        wrn = (kind == 1) || (kind == 3 && 1'($urandom));
        cycle(1'b1, s0n, s1v, s2n, wrn, kind == 3, g_ilv, a, cwd, cbe, g_oen);
    endtask

    task automatic stall();
        cycle(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              g_ilv, AW'($urandom), DW'($urandom), NB'($urandom), g_oen);
    endtask

    task automatic nop();
        op(0, '0, DW'($urandom), NB'($urandom));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd1234);
        dq_d[0] = '0; dq_d[1] = '0; dq_b[0] = '1; dq_b[1] = '1;
        repeat (3) @(posedge clk);
        // R1: reset state
        tag = "R1";
        check(rdata_oe === 1'b0 && rdata === '0, rdata, '0);
        @(negedge clk);
        rst_n = 1'b1;
        check(rdata_oe === 1'b0 && rdata === '0, rdata, '0);
        nop(); nop(); nop();

        // Prefill words 0..31
        tag = "R3";
        for (int a = 0; a < 32; a++) op(2, AW'(a), 32'h1000_0000 + a * 32'h0101_0101, '0);
        nop(); nop(); nop();
        for (int a = 0; a < 32; a++) op(1, AW'(a), '0, '1);

        // R2/R3: single write, later read
        tag = "R2";
        op(2, 8'd5, 32'hA5A5_1234, 4'b0000); nop(); nop(); nop();
        op(1, 8'd5, 32'hDEAD_BEEF, 4'b0000); nop(); nop();

        // R4: partial lane write (lanes 0 and 2)
        tag = "R4";
        op(2, 8'd6, 32'hCAFE_F00D, 4'b1010); nop(); nop(); nop();
        op(1, 8'd6, '0, '1); nop(); nop();

        // R10: read right behind a write to the same word
        tag = "R10";
        op(2, 8'd7, 32'h7777_0001, 4'b0110); op(1, 8'd7, '0, '1); nop(); nop();
        op(2, 8'd8, 32'h8888_0002, 4'b0000); nop(); op(1, 8'd8, '0, '1); nop(); nop();

        // R9: alternating write/read every cycle
        tag = "R9";
        for (int i = 0; i < 10; i++) begin
            op(2, AW'(10 + i), DW'($urandom), NB'($urandom));
            op(1, AW'(10 + (i % 3)), '0, '1);
        end
        nop(); nop(); nop();

        // R7/R8: linear then interleaved write bursts, read back singly and by burst
        tag = "R8";
        g_ilv = 0;
        op(2, 8'h12, 32'h0000_00A0, 4'b0000);
        for (int i = 1; i < 4; i++) op(3, 8'hFF, 32'h0000_00A0 + i, 4'b0000);
        nop(); nop(); nop();
        g_ilv = 1;
        op(2, 8'h16, 32'h0000_00B0, 4'b0000);
        for (int i = 1; i < 4; i++) op(3, 8'h00, 32'h0000_00B0 + i, 4'b0000);
        nop(); nop(); nop();
        for (int a = 16; a < 24; a++) op(1, AW'(a), '0, '1);
        tag = "R7";
        op(1, 8'h17, '0, '1);
        for (int i = 1; i < 4; i++) op(3, 8'h00, '0, '1);
        g_ilv = 0;
        op(1, 8'h11, '0, '1);
        for (int i = 1; i < 4; i++) op(3, 8'h00, '0, '1);
        nop(); nop(); nop();

        // R6: each select inactive in turn, write attempt must be ignored
        tag = "R6";
        for (int b = 1; b <= 3; b++) begin
            g_selbad = b;
            op(0, 8'd9, 32'hBAD0_0000 + b, 4'b0000);
            op(3, 8'd9, 32'hBAD1_0000 + b, 4'b0000);
            nop(); nop();
            op(1, 8'd9, '0, '1); nop(); nop();
        end
        g_selbad = 1;

        // R5: stalls inside a read and a write pipeline
        tag = "R5";
        op(1, 8'd5, '0, '1); stall(); stall(); op(2, 8'd4, 32'h5555_AAAA, 4'b0000);
        stall(); stall(); stall(); nop(); stall(); nop(); stall(); nop();
        op(1, 8'd4, '0, '1); stall(); nop(); stall(); nop();

        // R11: output enable gating
        tag = "R11";
        g_oen = 1;
        op(1, 8'd3, '0, '1); nop(); nop();
        g_oen = 0; nop();
        op(1, 8'd3, '0, '1); nop(); g_oen = 1; nop(); g_oen = 0; nop();

        // Random mix
        tag = "R9 random";
        for (int i = 0; i < 4000; i++) begin
            int k;
            if (($urandom % 8) == 0) begin stall(); continue; end
            k = $urandom % 10;
            g_oen = (($urandom % 6) == 0);
            g_selbad = 1 + ($urandom % 3);
            if (k < 3) op(1, AW'($urandom % 32), DW'($urandom), NB'($urandom));
            else if (k < 6) begin
                g_ilv = 1'($urandom);
                op(2, AW'($urandom % 32), DW'($urandom), NB'($urandom));
            end
            else if (k < 8) op(3, AW'($urandom), DW'($urandom), NB'($urandom));
            else op(0, AW'($urandom % 32), DW'($urandom), NB'($urandom));
        end
        g_oen = 0;
        nop(); nop(); nop();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule